// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns a single operation request into the series of bus write cycles that a parallel NOR flash expects before it will program or erase. A request carries an operation code, a target address and a data byte. The block plays out a two-write unlock preamble to two fixed addresses, then the command byte, then any operand. It spaces the writes with a settle gap of a parameterised number of clock cycles. A per-request bit removes the gap.

The two unlock addresses can be exchanged, for parts that decode them the other way round. Both can be cut down by one of several address masks. For a byte program, the block hands control to an external ready poller once the last write is out. It then compares the byte read back with the intended data and replays the whole sequence on a mismatch, up to a bounded number of attempts. An all-ones data byte needs no programming, so the block reports success at once. Unknown operation codes are refused with an error pulse.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: Every sequence except the reset opens with 0xAA written to the first unlock address, then 0x55 to the second. These are 0x5555 and 0x2AAA when `swap_i`=0, and 0x2AAA and 0x5555 when `swap_i`=1.
- R2: The unlock and command addresses are ANDed with a mask chosen by `mask_sel_i`: 0 selects 0xFFFF, 1 selects 0x07FF, 2 selects 0x0FFF and 3 selects 0xFFFF. The target address passes unmasked.
- R3: Operation code 0 (byte program) writes the unlock pair, then 0xA0 to the first unlock address, then the data byte to the target address. It then raises `poll_req_o` until `poll_done_i`.
- R4: Operation code 1 (sector erase) writes the unlock pair, then 0x80 to the first unlock address, the unlock pair again, and 0x30 to the target address: six writes.
- R5: Operation code 2 (block erase) is the same as R4 but ends with 0x50 to the target address. Operation code 3 (chip erase) ends with 0x10 to the first unlock address.
- R6: Operation code 4 (reset) is a single write of 0xF0 to the first unlock address.
- R7: A byte program whose data is 0xFF produces no bus write. It pulses `done_o` in the cycle after the request.
- R8: When the readback at `poll_done_i` differs from the data, the program sequence is replayed from its first write. After MAX_TRIES mismatching attempts, `err_o` pulses and `done_o` does not. `done_o` and `err_o` never pulse together.
- R9: With `zero_gap_i`=0, each write in a sequence is followed by GAP_CYC cycles without a write. With `zero_gap_i`=1, the writes of a sequence come on consecutive cycles, and each cycle with `bus_we_o` high is one write.
- R10: Operation codes 5 to 7 produce no bus write. They pulse `err_o` in the cycle after the request, and the block stays idle.
- R11: After reset, `bus_we_o`, `poll_req_o`, `busy_o`, `done_o` and `err_o` are low.
- R12: `busy_o` is high from the cycle after an accepted request until the cycle of completion. A `start_i` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled while idle |
| op_i | input | 3 | Operation code (0 program, 1 sector erase, 2 block erase, 3 chip erase, 4 reset) |
| addr_i | input | ADDR_W | Target address for program or erase |
| data_i | input | 8 | Byte to program |
| swap_i | input | 1 | Exchange the two unlock addresses |
| mask_sel_i | input | 2 | Unlock address mask select |
| zero_gap_i | input | 1 | Drop the settle gap between writes |
| bus_we_o | output | 1 | Write qualifier, one write per high cycle |
| bus_addr_o | output | ADDR_W | Write address |
| bus_data_o | output | 8 | Write data |
| poll_req_o | output | 1 | Request to the ready poller |
| poll_done_i | input | 1 | Poller finished, readback valid |
| rd_data_i | input | 8 | Byte read back at the target |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Failure or refused-opcode pulse |

## Verification
Each operation code is run with a distinct combination of swap and mask select. This catches a swapped unlock pair, a wrong mask constant, or a mask applied to the target address. Programs are run with readbacks that match at once, match after three misses, and never match. This separates a correct replay from a replay that starts mid-sequence or miscounts its attempts. The all-ones byte, a refused opcode and a request issued while busy must all leave the bus silent. Write spacing is measured with and without the gap.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
   typedef enum logic [2:0] {
      OP_PROG = 3'd0,
      OP_SECT = 3'd1,
      OP_BLK  = 3'd2,
      OP_CHIP = 3'd3,
      OP_RST  = 3'd4
   } nor_op_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_WRITE,
      S_GAP,
      S_POLL
   } seq_state_e;

   localparam logic [15:0] UNLOCK_LO = 16'h5555;
   localparam logic [15:0] UNLOCK_HI = 16'h2AAA;
   localparam logic [7:0]  KEY_ONE   = 8'hAA;
   localparam logic [7:0]  KEY_TWO   = 8'h55;
   localparam logic [7:0]  CMD_PROG  = 8'hA0;
   localparam logic [7:0]  CMD_ERSU  = 8'h80;
   localparam logic [7:0]  CMD_SECT  = 8'h30;
   localparam logic [7:0]  CMD_BLK   = 8'h50;
   localparam logic [7:0]  CMD_CHIP  = 8'h10;
   localparam logic [7:0]  CMD_RST   = 8'hF0;
endpackage

// File: rtl/nor_unlock_addr.sv
module nor_unlock_addr #(
   parameter int ADDR_W = 20
) (
   input  logic              swap_i,
   input  logic [1:0]        mask_sel_i,
   output logic [ADDR_W-1:0] first_o,
   output logic [ADDR_W-1:0] second_o
);
   import nor_seq_pkg::*;

   localparam int PAD_W = ADDR_W - 16;

   logic [15:0] mask;
   logic [15:0] a_raw;
   logic [15:0] b_raw;

   always_comb begin
      case (mask_sel_i)
         2'd1:    mask = 16'h07FF;
         2'd2:    mask = 16'h0FFF;
         default: mask = 16'hFFFF;
      endcase
      a_raw = swap_i ? UNLOCK_HI : UNLOCK_LO;
      b_raw = swap_i ? UNLOCK_LO : UNLOCK_HI;
   end

   generate
      if (ADDR_W < 16) begin : g_bad_width
         $error("nor_unlock_addr: ADDR_W must be at least 16");
      end
      if (PAD_W > 0) begin : g_pad
         assign first_o  = {{PAD_W{1'b0}}, a_raw & mask};
         assign second_o = {{PAD_W{1'b0}}, b_raw & mask};
      end else begin : g_exact
         assign first_o  = a_raw & mask;
         assign second_o = b_raw & mask;
      end
   endgenerate
endmodule

// File: rtl/nor_gap_timer.sv
module nor_gap_timer #(
   parameter int GAP_CYC = 1250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expire_o
);
   localparam int CW = $clog2(GAP_CYC + 1);
   localparam logic [CW-1:0] RELOAD = CW'(GAP_CYC - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("nor_gap_timer: GAP_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= RELOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expire_o = (cnt_q == '0);

   p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= RELOAD);
   p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == RELOAD));
endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer #(
   parameter int ADDR_W    = 20,
   parameter int GAP_CYC   = 1250,
   parameter int MAX_TRIES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        data_i,
   input  logic              swap_i,
   input  logic [1:0]        mask_sel_i,
   input  logic              zero_gap_i,
   output logic              bus_we_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [7:0]        bus_data_o,
   output logic              poll_req_o,
   input  logic              poll_done_i,
   input  logic [7:0]        rd_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);
   import nor_seq_pkg::*;

   localparam int TW = $clog2(MAX_TRIES + 1);
   localparam logic [TW-1:0] LAST_TRY = TW'(MAX_TRIES - 1);

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("nor_cmd_sequencer: MAX_TRIES must be at least 1");
      end
   endgenerate

   seq_state_e        state_q;
   nor_op_e           op_q;
   logic [ADDR_W-1:0] tgt_q;
   logic [7:0]        dat_q;
   logic              swap_q;
   logic [1:0]        msel_q;
   logic              zg_q;
   logic [2:0]        step_q;
   logic [TW-1:0]     tries_q;
   logic              done_q;
   logic              err_q;

   logic [ADDR_W-1:0] ua;
   logic [ADDR_W-1:0] ub;
   logic [ADDR_W-1:0] wa;
   logic [7:0]        wd;
   logic [2:0]        last_step;
   logic              expire;
   logic              advance;
   logic              op_ok;

   nor_unlock_addr #(.ADDR_W(ADDR_W)) u_addr (
      .swap_i     (swap_q),
      .mask_sel_i (msel_q),
      .first_o    (ua),
      .second_o   (ub)
   );

   nor_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (state_q == S_WRITE && !zg_q),
      .expire_o (expire)
   );

   assign op_ok = (op_i <= 3'd4);

   // Step table: address and data of the current write
   always_comb begin
      wa = ua;
      wd = KEY_ONE;
      case (op_q)
         OP_RST: begin
            last_step = 3'd0;
            wd        = CMD_RST;
         end
         OP_PROG: begin
            last_step = 3'd3;
            case (step_q)
               3'd0:    begin wa = ua;    wd = KEY_ONE;  end
               3'd1:    begin wa = ub;    wd = KEY_TWO;  end
               3'd2:    begin wa = ua;    wd = CMD_PROG; end
               default: begin wa = tgt_q; wd = dat_q;    end
            endcase
         end
         default: begin
            last_step = 3'd5;
            case (step_q)
               3'd0, 3'd3: begin wa = ua; wd = KEY_ONE;  end
               3'd1, 3'd4: begin wa = ub; wd = KEY_TWO;  end
               3'd2:       begin wa = ua; wd = CMD_ERSU; end
               default: begin
                  wa = (op_q == OP_CHIP) ? ua : tgt_q;
                  case (op_q)
                     OP_SECT: wd = CMD_SECT;
                     OP_BLK:  wd = CMD_BLK;
                     default: wd = CMD_CHIP;
                  endcase
               end
            endcase
         end
      endcase
   end

   assign advance = (state_q == S_WRITE && zg_q) || (state_q == S_GAP && expire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         op_q    <= OP_PROG;
         tgt_q   <= '0;
         dat_q   <= '0;
         swap_q  <= 1'b0;
         msel_q  <= '0;
         zg_q    <= 1'b0;
         step_q  <= '0;
         tries_q <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            S_IDLE: if (start_i) begin
               if (!op_ok) begin
                  err_q <= 1'b1;
               end else if (op_i == 3'd0 && data_i == 8'hFF) begin
                  done_q <= 1'b1;
               end else begin
                  op_q    <= nor_op_e'(op_i);
                  tgt_q   <= addr_i;
                  dat_q   <= data_i;
                  swap_q  <= swap_i;
                  msel_q  <= mask_sel_i;
                  zg_q    <= zero_gap_i;
                  step_q  <= '0;
                  tries_q <= '0;
                  state_q <= S_WRITE;
               end
            end
            S_WRITE: if (!zg_q) state_q <= S_GAP;
            S_POLL: if (poll_done_i) begin
               if (rd_data_i == dat_q) begin
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else if (tries_q == LAST_TRY) begin
                  err_q   <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  tries_q <= tries_q + 1'b1;
                  step_q  <= '0;
                  state_q <= S_WRITE;
               end
            end
            default: ;
         endcase
         if (advance) begin
            if (step_q == last_step) begin
               if (op_q == OP_PROG) begin
                  state_q <= S_POLL;
               end else begin
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end
            end else begin
               step_q  <= step_q + 1'b1;
               state_q <= S_WRITE;
            end
         end
      end
   end

   assign bus_we_o   = (state_q == S_WRITE);
   assign bus_addr_o = bus_we_o ? wa : '0;
   assign bus_data_o = bus_we_o ? wd : 8'h00;
   assign poll_req_o = (state_q == S_POLL);
   assign busy_o     = (state_q != S_IDLE);
   assign done_o     = done_q;
   assign err_o      = err_q;

   p_first_unlock_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_o) && op_q != OP_RST) |-> (bus_we_o && bus_data_o == KEY_ONE));
   p_ff_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && op_i == 3'd0 && data_i == 8'hFF) |=> (done_o && !busy_o && !bus_we_o));
   p_outcome_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));
   p_tries_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q <= LAST_TRY);
   p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_o && !zg_q) |=> !bus_we_o);
   p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && op_i > 3'd4) |=> (err_o && !busy_o && !bus_we_o));
   p_poll_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_req_o && !poll_done_i) |=> poll_req_o);
endmodule

// File: tb/nor_cmd_sequencer_test.sv
module nor_cmd_sequencer_test;
   localparam int AW  = 20;
   localparam int GAP = 4;
   localparam int MT  = 16;
   localparam int NREC = 80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [2:0]    op_i = '0;
   logic [AW-1:0] addr_i = '0;
   logic [7:0]    data_i = '0;
   logic          swap_i = 1'b0;
   logic [1:0]    mask_sel_i = '0;
   logic          zero_gap_i = 1'b0;
   logic          bus_we_o;
   logic [AW-1:0] bus_addr_o;
   logic [7:0]    bus_data_o;
   logic          poll_req_o;
   logic          poll_done_i = 1'b0;
   logic [7:0]    rd_data_i = '0;
   logic          busy_o;
   logic          done_o;
   logic          err_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int n_wr = 0;
   int fail_left = 0;
   logic [7:0] exp_byte = '0;
   logic got_done;
   logic got_err;
   logic [AW-1:0] wa [NREC];
   logic [7:0]    wd [NREC];
   int            wt [NREC];

   nor_cmd_sequencer #(.ADDR_W(AW), .GAP_CYC(GAP), .MAX_TRIES(MT)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
      .data_i(data_i), .swap_i(swap_i), .mask_sel_i(mask_sel_i), .zero_gap_i(zero_gap_i),
      .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
      .poll_req_o(poll_req_o), .poll_done_i(poll_done_i), .rd_data_i(rd_data_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (bus_we_o && n_wr < NREC) begin
         wa[n_wr] <= bus_addr_o;
         wd[n_wr] <= bus_data_o;
         wt[n_wr] <= cyc;
         n_wr     <= n_wr + 1;
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (poll_req_o && !poll_done_i) begin
            repeat (2) @(negedge clk);
            poll_done_i = 1'b1;
            rd_data_i = (fail_left > 0) ? ~exp_byte : exp_byte;
            if (fail_left > 0) fail_left = fail_left - 1;
            @(negedge clk);
            poll_done_i = 1'b0;
         end
      end
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] unl(input logic second, input logic sw, input logic [1:0] ms);
      logic [15:0] m;
      logic [15:0] v;
      m = (ms == 2'd1) ? 16'h07FF : (ms == 2'd2) ? 16'h0FFF : 16'hFFFF;
      v = ((second ^ sw) ? 16'h2AAA : 16'h5555) & m;
      return AW'(v);
   endfunction

   task automatic launch(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                         input logic sw, input logic [1:0] ms, input logic zg, input int fails);
      @(negedge clk);
      n_wr = 0;
      fail_left = fails;
      exp_byte = d;
      op_i = op; addr_i = a; data_i = d; swap_i = sw; mask_sel_i = ms; zero_gap_i = zg;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_end(input string tag);
      got_done = 1'b0;
      got_err = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         if (done_o) got_done = 1'b1;
         if (err_o) got_err = 1'b1;
         if (got_done || got_err) break;
         @(negedge clk);
      end
      chk(got_done || got_err, {tag, " completion"}, 0, 1);
      repeat (GAP + 3) @(negedge clk);
   endtask

   task automatic exp_wr(input int i, input logic [AW-1:0] a, input logic [7:0] d, input string tag);
      chk(wa[i] == a, {tag, " addr"}, int'(wa[i]), int'(a));
      chk(wd[i] == d, {tag, " data"}, int'(wd[i]), int'(d));
   endtask

   task automatic t_reset_state();
      chk(!bus_we_o && !poll_req_o && !busy_o && !done_o && !err_o, "R11 reset outputs",
          {bus_we_o, poll_req_o, busy_o, done_o, err_o}, 0);
   endtask

   task automatic t_program_plain();
      logic [AW-1:0] a1, a2;
      a1 = unl(1'b0, 1'b0, 2'd0);
      a2 = unl(1'b1, 1'b0, 2'd0);
      launch(3'd0, 20'h12345, 8'h3C, 1'b0, 2'd0, 1'b0, 0);
      chk(busy_o, "R12 busy after start", busy_o, 1);
      wait_end("R3 program");
      chk(got_done && !got_err, "R3 program done", got_done, 1);
      chk(n_wr == 4, "R3 program write count", n_wr, 4);
      exp_wr(0, a1, 8'hAA, "R1 first unlock");
      exp_wr(1, a2, 8'h55, "R1 second unlock");
      exp_wr(2, a1, 8'hA0, "R3 command");
      exp_wr(3, 20'h12345, 8'h3C, "R3 data");
      for (int i = 1; i < 4; i++)
         chk(wt[i] - wt[i-1] == GAP + 1, "R9 gap spacing", wt[i] - wt[i-1], GAP + 1);
      chk(!busy_o, "R12 idle after done", busy_o, 0);
   endtask

   task automatic t_program_swap_mask();
      launch(3'd0, 20'hABCDE, 8'h5A, 1'b1, 2'd1, 1'b0, 0);
      wait_end("R2 program swapped");
      chk(n_wr == 4, "R2 write count", n_wr, 4);
      exp_wr(0, 20'h002AA, 8'hAA, "R1 R2 swapped first");
      exp_wr(1, 20'h00555, 8'h55, "R1 R2 swapped second");
      exp_wr(2, 20'h002AA, 8'hA0, "R2 command");
      exp_wr(3, 20'hABCDE, 8'h5A, "R2 target unmasked");
   endtask

   task automatic t_sector_erase();
      launch(3'd1, 20'h4F000, 8'h00, 1'b0, 2'd2, 1'b1, 0);
      wait_end("R4 sector");
      chk(got_done, "R4 sector done", got_done, 1);
      chk(n_wr == 6, "R4 write count", n_wr, 6);
      exp_wr(0, 20'h00555, 8'hAA, "R4 w0");
      exp_wr(1, 20'h00AAA, 8'h55, "R4 w1");
      exp_wr(2, 20'h00555, 8'h80, "R4 w2");
      exp_wr(3, 20'h00555, 8'hAA, "R4 w3");
      exp_wr(4, 20'h00AAA, 8'h55, "R4 w4");
      exp_wr(5, 20'h4F000, 8'h30, "R4 w5");
      for (int i = 1; i < 6; i++)
         chk(wt[i] - wt[i-1] == 1, "R9 zero gap spacing", wt[i] - wt[i-1], 1);
   endtask

   task automatic t_block_chip();
      launch(3'd2, 20'h80000, 8'h00, 1'b1, 2'd0, 1'b0, 0);
      wait_end("R5 block");
      chk(n_wr == 6, "R5 block count", n_wr, 6);
      exp_wr(2, 20'h02AAA, 8'h80, "R5 block setup");
      exp_wr(5, 20'h80000, 8'h50, "R5 block final");
      launch(3'd3, 20'h77777, 8'h00, 1'b0, 2'd3, 1'b1, 0);
      wait_end("R5 chip");
      chk(n_wr == 6, "R5 chip count", n_wr, 6);
      exp_wr(4, 20'h02AAA, 8'h55, "R5 chip unlock");
      exp_wr(5, 20'h05555, 8'h10, "R5 chip final");
   endtask

   task automatic t_reset_op();
      launch(3'd4, 20'h11111, 8'h00, 1'b0, 2'd0, 1'b0, 0);
      wait_end("R6 reset op");
      chk(got_done && n_wr == 1, "R6 single write", n_wr, 1);
      exp_wr(0, 20'h05555, 8'hF0, "R6 reset write");
   endtask

   task automatic t_all_ones();
      launch(3'd0, 20'h00010, 8'hFF, 1'b0, 2'd0, 1'b0, 0);
      wait_end("R7 all ones");
      chk(got_done && !got_err, "R7 done", got_done, 1);
      chk(n_wr == 0, "R7 no writes", n_wr, 0);
   endtask

   task automatic t_retry();
      launch(3'd0, 20'h00020, 8'h81, 1'b0, 2'd0, 1'b1, 3);
      wait_end("R8 retry");
      chk(got_done && !got_err, "R8 retry done", got_done, 1);
      chk(n_wr == 16, "R8 retry writes", n_wr, 16);
      exp_wr(12, 20'h05555, 8'hAA, "R8 replay prefix");
      exp_wr(15, 20'h00020, 8'h81, "R8 replay data");
   endtask

   task automatic t_exhaust();
      launch(3'd0, 20'h00030, 8'h42, 1'b0, 2'd0, 1'b1, MT);
      wait_end("R8 exhaust");
      chk(got_err && !got_done, "R8 exhaust error", got_err, 1);
      chk(n_wr == 4 * MT, "R8 attempt count", n_wr, 4 * MT);
      fail_left = 0;
   endtask

   task automatic t_bad_op();
      launch(3'd6, 20'h00040, 8'h00, 1'b0, 2'd0, 1'b0, 0);
      wait_end("R10 bad op");
      chk(got_err && !got_done, "R10 error pulse", got_err, 1);
      chk(n_wr == 0 && !busy_o, "R10 no writes", n_wr, 0);
   endtask

   task automatic t_busy_ignore();
      launch(3'd0, 20'h00050, 8'h99, 1'b0, 2'd0, 1'b0, 0);
      @(negedge clk);
      op_i = 3'd4; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_end("R12 ignore");
      chk(n_wr == 4, "R12 ignored start count", n_wr, 4);
      exp_wr(0, 20'h05555, 8'hAA, "R12 first write");
      exp_wr(3, 20'h00050, 8'h99, "R12 data write");
      repeat (3) @(negedge clk);
      chk(n_wr == 4 && !busy_o, "R12 no extra sequence", n_wr, 4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset_state();
      t_program_plain();
      t_program_swap_mask();
      t_sector_erase();
      t_block_chip();
      t_reset_op();
      t_all_ones();
      t_retry();
      t_exhaust();
      t_bad_op();
      t_busy_ignore();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule